// File: doc/BRIEF.md
# Multilevel Redundant Switching-State Enumerator

This block serves a multilevel diode-clamped three-phase inverter. Each phase is clamped to one of `LEVELS` voltage levels. The block accepts one output voltage state: three phase levels, each from 0 to `LEVELS-1`. Adding the same integer to all three phase levels leaves every line-to-line voltage unchanged. The block uses this to work out every switch combination that yields the same line-to-line voltage as the supplied state.

When a state is accepted, the block reports three status values:
- how many extra redundant combinations exist above the supplied state, which is `LEVELS-1` minus its largest phase level;
- whether the state is a zero-voltage state, meaning all three levels are equal;
- whether the state is canonical, meaning its smallest level is 0.

The block then streams the alternatives one per beat. It starts from the state shifted down until its lowest phase sits at level 0, and raises all three phases by one on each beat until the highest phase reaches `LEVELS-1`. A flag marks the final beat. A state with a phase level above `LEVELS-1` is refused with a one-cycle error pulse, and nothing is streamed for it.

Both data paths are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. The input side is ready only while no enumeration is in progress, so one state is handled at a time. On the output side, a beat with `out_valid` high and `out_ready` low is held unchanged until it is taken. The status pins are plain registered outputs. They stay unchanged from the cycle after an in-range state is accepted until the next in-range state is accepted.

Top module: `redundancy_enum`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `lvl_err` is 0.
- R2: An accepted state with any phase level above `LEVELS-1` raises `lvl_err` for exactly the cycle after acceptance. No output beat follows it. Every in-range state leaves `lvl_err` at 0.
- R3: In the cycle after an in-range state is accepted, `spare_cnt` equals `LEVELS-1-max(x,y,z)`. It holds that value until the next in-range acceptance. Summed over all canonical states this gives `(LEVELS-1)^3`, which is 125 for six levels.
- R4: `zero_state` is 1 exactly when the accepted state has x = y = z.
- R5: `canonical` is 1 exactly when min(x,y,z) = 0. There are `LEVELS^3-(LEVELS-1)^3` such states, which is 91 for six levels.
- R6: Beat i (counting from 0) of an enumeration carries each phase level minus min(x,y,z), plus i. Consecutive beats differ by +1 in every phase.
- R7: An enumeration has exactly `LEVELS-(max-min)` beats. `out_last` is 1 on the final beat only. `out_valid` drops in the cycle after the final beat is taken.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all output fields hold their values into the next cycle.
- R9: `in_ready` is 0 from the cycle after an in-range state is accepted until its final beat is taken. Otherwise it is 1.
- R10: Every emitted phase level is at most `LEVELS-1`. Every emitted beat keeps the input's pairwise phase differences x-y and y-z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input state offered |
| in_ready | output | 1 | Block can take a state (idle) |
| in_x | input | LW | Phase A level |
| in_y | input | LW | Phase B level |
| in_z | input | LW | Phase C level |
| out_valid | output | 1 | Alternative state beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_x | output | LW | Phase A level of the beat |
| out_y | output | LW | Phase B level of the beat |
| out_z | output | LW | Phase C level of the beat |
| out_last | output | 1 | Final beat of the enumeration |
| spare_cnt | output | LW | Extra redundant combinations above the input |
| zero_state | output | 1 | Input was a zero-voltage state |
| canonical | output | 1 | Input had its minimum phase at level 0 |
| lvl_err | output | 1 | One-cycle pulse: input level out of range |

`LW` is `$clog2(LEVELS)`, which is 3 for the default of six levels.

## Verification
The assertions assume the consumer obeys the stream rules. In particular, they assume `out_ready` is only taken into account while a beat is presented, and that input fields are sampled only on the acceptance edge. The bench drives every input and `out_ready` at the falling edge, and offers a new state only after it has seen `in_ready` high. The sweep covers every 3-bit code on all three phases, so it includes the out-of-range codes 6 and 7 that must trigger `lvl_err`. The stepping and range properties rely on the walker being loaded only with in-range states; the error path guarantees this by never loading a refused state.

// File: rtl/redun_pkg.sv
package redun_pkg;
  typedef enum logic {
    ENUM_IDLE = 1'b0,
    ENUM_RUN  = 1'b1
  } enum_state_e;

  localparam int PHASES = 3;
endpackage

// File: rtl/phase_extrema.sv
module phase_extrema #(
  parameter int LEVELS = 6,
  parameter int LW     = $clog2(LEVELS),
  parameter int PHASES = 3
) (
  input  logic [PHASES*LW-1:0] lvl_flat,
  output logic [LW-1:0]        hi,
  output logic [LW-1:0]        lo,
  output logic                 in_range,
  output logic                 all_equal
);
  localparam logic [LW:0] TOP_LVL = (LW+1)'(LEVELS - 1);

  always_comb begin
    hi        = '0;
    lo        = '1;
    in_range  = 1'b1;
    all_equal = 1'b1;
    for (int p = 0; p < PHASES; p++) begin
      if (lvl_flat[p*LW +: LW] > hi) hi = lvl_flat[p*LW +: LW];
      if (lvl_flat[p*LW +: LW] < lo) lo = lvl_flat[p*LW +: LW];
      if ({1'b0, lvl_flat[p*LW +: LW]} > TOP_LVL) in_range = 1'b0;
      if (lvl_flat[p*LW +: LW] != lvl_flat[0 +: LW]) all_equal = 1'b0;
    end
  end
endmodule

// File: rtl/offset_walker.sv
module offset_walker #(
  parameter int LEVELS = 6,
  parameter int LW     = $clog2(LEVELS),
  parameter int PHASES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PHASES*LW-1:0] base_in,
  input  logic [LW-1:0]        span_in,
  input  logic                 step,
  output logic [PHASES*LW-1:0] beat_flat,
  output logic                 last
);
  logic [PHASES*LW-1:0] base_q;
  logic [LW-1:0]        k_q;
  logic [LW-1:0]        lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      k_q    <= '0;
      lim_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      k_q    <= '0;
      lim_q  <= LW'(LEVELS - 1) - span_in;
    end else if (step) begin
      k_q <= k_q + LW'(1);
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign beat_flat[p*LW +: LW] = base_q[p*LW +: LW] + k_q;
  end

  assign last = (k_q == lim_q);

  // R7
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    k_q <= lim_q);
endmodule

// File: rtl/redundancy_enum.sv
module redundancy_enum
  import redun_pkg::*;
#(
  parameter int LEVELS = 6,
  parameter int LW     = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_x,
  input  logic [LW-1:0] in_y,
  input  logic [LW-1:0] in_z,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_x,
  output logic [LW-1:0] out_y,
  output logic [LW-1:0] out_z,
  output logic          out_last,
  output logic [LW-1:0] spare_cnt,
  output logic          zero_state,
  output logic          canonical,
  output logic          lvl_err
);
  localparam int FW = PHASES * LW;

  enum_state_e   state_q;
  logic [FW-1:0] in_flat;
  logic [FW-1:0] norm_flat;
  logic [FW-1:0] beat_flat;
  logic [LW-1:0] hi, lo, span;
  logic          in_range, all_equal;
  logic          accept, load, step, last;

  assign in_flat = {in_z, in_y, in_x};

  phase_extrema #(.LEVELS(LEVELS), .LW(LW), .PHASES(PHASES)) u_extrema (
    .lvl_flat (in_flat),
    .hi       (hi),
    .lo       (lo),
    .in_range (in_range),
    .all_equal(all_equal)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_norm
    assign norm_flat[p*LW +: LW] = in_flat[p*LW +: LW] - lo;
  end
  assign span = hi - lo;

  assign in_ready  = (state_q == ENUM_IDLE);
  assign out_valid = (state_q == ENUM_RUN);
  assign accept    = in_valid && in_ready;
  assign load      = accept && in_range;
  assign step      = out_valid && out_ready && !last;

  offset_walker #(.LEVELS(LEVELS), .LW(LW), .PHASES(PHASES)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .base_in  (norm_flat),
    .span_in  (span),
    .step     (step),
    .beat_flat(beat_flat),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENUM_IDLE;
    end else begin
      case (state_q)
        ENUM_IDLE: if (load) state_q <= ENUM_RUN;
        ENUM_RUN:  if (out_ready && last) state_q <= ENUM_IDLE;
        default:   state_q <= ENUM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_cnt  <= '0;
      zero_state <= 1'b0;
      canonical  <= 1'b0;
      lvl_err    <= 1'b0;
    end else begin
      lvl_err <= accept && !in_range;
      if (load) begin
        spare_cnt  <= LW'(LEVELS - 1) - hi;
        zero_state <= all_equal;
        canonical  <= (lo == '0);
      end
    end
  end

  assign out_x    = beat_flat[0 +: LW];
  assign out_y    = beat_flat[LW +: LW];
  assign out_z    = beat_flat[2*LW +: LW];
  assign out_last = out_valid && last;

  // R2
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_err |-> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) &&
      $stable(out_y) && $stable(out_z) && $stable(out_last)));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_x == $past(out_x) + LW'(1) &&
       out_y == $past(out_y) + LW'(1) && out_z == $past(out_z) + LW'(1)));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R10
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x <= LW'(LEVELS - 1) && out_y <= LW'(LEVELS - 1) &&
                   out_z <= LW'(LEVELS - 1)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/test_redundancy_enum.sv
module test_redundancy_enum;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS     = 6;
  localparam int LW         = $clog2(LEVELS);
  localparam int CODES      = 1 << LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_valid, out_ready, out_last;
  logic [LW-1:0] in_x, in_y, in_z, out_x, out_y, out_z, spare_cnt;
  logic          zero_state, canonical, lvl_err;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  mx, mn, beats, canon_n, spare_sum, valid_n, stall_ctr;
  int  hx, hy, hz, hl;

  always #(CLK_PERIOD/2) clk = ~clk;

  redundancy_enum #(.LEVELS(LEVELS), .LW(LW)) i_redundancy_enum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_valid(out_valid),
    .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_z(out_z),
    .out_last(out_last), .spare_cnt(spare_cnt), .zero_state(zero_state),
    .canonical(canonical), .lvl_err(lvl_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_x = '0; in_y = '0; in_z = '0;
    canon_n = 0; spare_sum = 0; valid_n = 0; stall_ctr = 0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(lvl_err == 1'b0, "R1 lvl_err", int'(lvl_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int x = 0; x < CODES; x++) begin
      for (int y = 0; y < CODES; y++) begin
        for (int z = 0; z < CODES; z++) begin
          chk(in_ready == 1'b1, "R9 idle ready", int'(in_ready), 1);
          in_valid = 1'b1;
          in_x = LW'(x); in_y = LW'(y); in_z = LW'(z);
          @(negedge clk);
          in_valid = 1'b0;
          mx = (x > y) ? x : y; mx = (z > mx) ? z : mx;
          mn = (x < y) ? x : y; mn = (z < mn) ? z : mn;
          if (mx > LEVELS - 1) begin
            chk(lvl_err == 1'b1, "R2 err pulse", int'(lvl_err), 1);
            chk(out_valid == 1'b0, "R2 no beat", int'(out_valid), 0);
          end else begin
            valid_n++;
            chk(lvl_err == 1'b0, "R2 no err", int'(lvl_err), 0);
            chk(int'(spare_cnt) == LEVELS - 1 - mx, "R3 spare", int'(spare_cnt), LEVELS - 1 - mx);
            chk(zero_state == (x == y && y == z), "R4 zero", int'(zero_state), int'(x == y && y == z));
            chk(canonical == (mn == 0), "R5 canonical", int'(canonical), int'(mn == 0));
            chk(in_ready == 1'b0, "R9 busy", int'(in_ready), 0);
            if (mn == 0) begin
              canon_n++;
              spare_sum += int'(spare_cnt);
            end
            beats = LEVELS - (mx - mn);
            for (int i = 0; i < beats; i++) begin
              stall_ctr++;
              if (stall_ctr % 5 == 0) begin
                out_ready = 1'b0;
                hx = int'(out_x); hy = int'(out_y); hz = int'(out_z); hl = int'(out_last);
                @(negedge clk);
                chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
                chk(int'(out_x) == hx && int'(out_y) == hy && int'(out_z) == hz && int'(out_last) == hl,
                    "R8 beat held", int'(out_x), hx);
              end
              chk(out_valid == 1'b1, "R7 beat present", int'(out_valid), 1);
              chk(int'(out_x) == x - mn + i, "R6 phase A", int'(out_x), x - mn + i);
              chk(int'(out_y) == y - mn + i, "R6 phase B", int'(out_y), y - mn + i);
              chk(int'(out_z) == z - mn + i, "R6 phase C", int'(out_z), z - mn + i);
              chk(out_last == (i == beats - 1), "R7 last flag", int'(out_last), int'(i == beats - 1));
              chk(int'(out_x) <= LEVELS - 1 && int'(out_y) <= LEVELS - 1 && int'(out_z) <= LEVELS - 1 &&
                  int'(out_x) - int'(out_y) == x - y && int'(out_y) - int'(out_z) == y - z,
                  "R10 range and differences", int'(out_x) - int'(out_y), x - y);
              out_ready = 1'b1;
              @(negedge clk);
              out_ready = 1'b0;
            end
            chk(out_valid == 1'b0, "R7 ends", int'(out_valid), 0);
            chk(int'(spare_cnt) == LEVELS - 1 - mx, "R3 spare held", int'(spare_cnt), LEVELS - 1 - mx);
          end
        end
      end
    end

    chk(valid_n == LEVELS**3, "R2 in-range total", valid_n, LEVELS**3);
    chk(canon_n == LEVELS**3 - (LEVELS-1)**3, "R5 distinct total", canon_n, LEVELS**3 - (LEVELS-1)**3);
    chk(spare_sum == (LEVELS-1)**3, "R3 redundant total", spare_sum, (LEVELS-1)**3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule